// File: doc/BRIEF.md
# Audio Clock Generator

This block turns one peripheral clock into the three clocks an audio serial link needs: an oversampling master clock, a serial bit clock, and a left/right word-select clock. Each clock comes from a small divider whose setting is a field on the block's inputs. The master clock divides by any integer from 1 to 64. The bit clock divides by an even ratio from 2 to 512. The word-select clock spends a set number of bit-clock cycles on each channel. A one-cycle strobe marks every word-select transition, so that a serializer beside the block can load the next sample.

The fields are captured only when the enable rises. While the enable is low every counter is held cleared and every output is low. A word-select code above the supported range is clamped to the longest legal half-period and flagged. A second flag reports when one full word-select frame does not hold a whole number of master-clock periods, which means the master and sample clocks drift against each other.

Top module: `audio_clk_gen`

## Requirements
- R1: With master field M from 1 to 63 the master clock repeats every M+1 peripheral cycles. It is high for ceil((M+1)/2) cycles and low for floor((M+1)/2) cycles.
- R2: With master field M = 0, while running the master clock follows the peripheral clock level: high in the clock's high phase and low in its low phase.
- R3: With bit field B (0 to 255) each high phase and each low phase of the bit clock lasts exactly B+1 peripheral cycles.
- R4: With word code W from 0 to 16, word-select stays at each level for W+16 bit-clock periods, that is (B+1)*2*(W+16) peripheral cycles. It changes only in the cycle where the bit clock falls.
- R5: Word codes 17 to 31 act as code 16 (32 bit clocks per half) and drive the config-error flag to 1 while running. Codes 0 to 16 leave the flag at 0.
- R6: The strobe is high for exactly the cycles in which word-select takes a new value.
- R7: The sync-error flag goes to 1 at the end of the first full frame if (B+1)*2*(W'+16)*2 is not a multiple of M+1, where W' is the clamped code. It stays 0 otherwise.
- R8: Two cycles after the enable goes low, all outputs are low. Field changes while running have no effect until the enable rises again, and they are then used.
- R9: After reset, with the enable low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst | input | 1 | synchronous active-high reset |
| en | input | 1 | run enable; fields captured on its rise |
| mclk_div | input | 6 | master divider field M (ratio M+1) |
| bclk_div | input | 8 | bit divider field B (ratio 2*(B+1)) |
| ws_code | input | 5 | word-select half-period code W (W+16 bit clocks) |
| mclk_o | output | 1 | master clock |
| bclk_o | output | 1 | bit clock |
| ws_o | output | 1 | word-select clock, low on the first channel |
| ws_strobe_o | output | 1 | one-cycle pulse on each word-select change |
| cfg_err_o | output | 1 | reserved word code was clamped |
| sync_err_o | output | 1 | frame length not a multiple of the master period |

## Verification
The hardest situation to reach is the sync check. It is only judged at the end of a complete frame, and only when the frame length is not a multiple of the master ratio. The stimulus table holds ratio sets where the frame is a multiple and sets where it is not, including one with a clamped code. Each set runs for more than two frames before the flags and the measured periods are sampled. The ignore-while-running rule is reached by changing every field mid-run, checking the old bit period, and then toggling the enable.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  localparam int MDIV_W   = 6;
  localparam int BDIV_W   = 8;
  localparam int WCODE_W  = 5;
  localparam int WS_BASE  = 16;
  localparam int WS_MAXC  = 16;
endpackage

// File: rtl/acg_mclk_div.sv
module acg_mclk_div #(
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [MW-1:0] div,
  output logic          mclk_o,
  output logic [MW-1:0] phase_o
);
  logic [MW-1:0] cnt;
  logic          mclk_r;
  logic [MW:0]   hi_len;
  logic          bypass;

  assign hi_len = ({1'b0, div} + (MW+1)'(2)) >> 1;
  assign bypass = (div == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      mclk_r <= 1'b0;
    end else begin
      cnt    <= (cnt == div) ? '0 : cnt + 1'b1;
      mclk_r <= ({1'b0, cnt} < hi_len);
    end
  end

  assign mclk_o  = run & (bypass ? clk : mclk_r);
  assign phase_o = cnt;
endmodule

// File: rtl/acg_bclk_div.sv
module acg_bclk_div #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [BW-1:0] div,
  output logic          bclk_o,
  output logic          fall_o
);
  logic [BW-1:0] cnt;
  logic          bclk_r;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      bclk_r <= 1'b0;
    end else if (cnt == div) begin
      cnt    <= '0;
      bclk_r <= ~bclk_r;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  assign bclk_o = bclk_r;
  assign fall_o = run & bclk_r & (cnt == div);
endmodule

// File: rtl/acg_ws_gen.sv
module acg_ws_gen #(
  parameter int LW = 6,
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          fall_i,
  input  logic [LW-1:0] last_i,
  input  logic [MW-1:0] mphase_i,
  input  logic [MW-1:0] mdiv_i,
  output logic          ws_o,
  output logic          stb_o,
  output logic          sync_err_o
);
  logic [LW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      fcnt       <= '0;
      ws_o       <= 1'b0;
      stb_o      <= 1'b0;
      sync_err_o <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (fall_i) begin
        if (fcnt == last_i) begin
          fcnt  <= '0;
          ws_o  <= ~ws_o;
          stb_o <= 1'b1;
          if (ws_o && (mphase_i != mdiv_i))
            sync_err_o <= 1'b1;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import audio_clk_pkg::*;
#(
  parameter int MW   = MDIV_W,
  parameter int BW   = BDIV_W,
  parameter int CW   = WCODE_W,
  parameter int BASE = WS_BASE,
  parameter int MAXC = WS_MAXC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [MW-1:0] mclk_div,
  input  logic [BW-1:0] bclk_div,
  input  logic [CW-1:0] ws_code,
  output logic          mclk_o,
  output logic          bclk_o,
  output logic          ws_o,
  output logic          ws_strobe_o,
  output logic          cfg_err_o,
  output logic          sync_err_o
);
  localparam int LW = $clog2(BASE + MAXC + 1);

  logic          run;
  logic [MW-1:0] mdiv_q;
  logic [BW-1:0] bdiv_q;
  logic [LW-1:0] last_q;
  logic          cfg_err_q;
  logic          reserved;
  logic [MW-1:0] mphase;
  logic          fall;

  assign reserved = (ws_code > CW'(MAXC));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run       <= 1'b0;
      cfg_err_q <= 1'b0;
    end else if (!run) begin
      run       <= 1'b1;
      mdiv_q    <= mclk_div;
      bdiv_q    <= bclk_div;
      last_q    <= reserved ? LW'(MAXC + BASE - 1)
                            : LW'(ws_code) + LW'(BASE - 1);
      cfg_err_q <= reserved;
    end
  end

  acg_mclk_div #(.MW(MW)) u_mclk (
    .clk(clk), .rst(rst), .run(run), .div(mdiv_q),
    .mclk_o(mclk_o), .phase_o(mphase)
  );

  acg_bclk_div #(.BW(BW)) u_bclk (
    .clk(clk), .rst(rst), .run(run), .div(bdiv_q),
    .bclk_o(bclk_o), .fall_o(fall)
  );

  acg_ws_gen #(.LW(LW), .MW(MW)) u_ws (
    .clk(clk), .rst(rst), .run(run), .fall_i(fall), .last_i(last_q),
    .mphase_i(mphase), .mdiv_i(mdiv_q),
    .ws_o(ws_o), .stb_o(ws_strobe_o), .sync_err_o(sync_err_o)
  );

  assign cfg_err_o = cfg_err_q;
endmodule

// File: rtl/acg_checker.sv
module acg_checker #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          run,
  input logic [BW-1:0] bdiv_q,
  input logic          mclk_o,
  input logic          bclk_o,
  input logic          ws_o,
  input logic          ws_strobe_o,
  input logic          cfg_err_o,
  input logic          sync_err_o
);
  logic [BW:0] level_len;
  logic        bclk_prev;

  always_ff @(posedge clk) begin
    bclk_prev <= bclk_o;
    if (rst || !run)             level_len <= '0;
    else if (bclk_o != bclk_prev) level_len <= (BW+1)'(1);
    else                          level_len <= level_len + 1'b1;
  end

  AST_BCLK_PHASE: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (bclk_o != $past(bclk_o))) |-> (level_len == {1'b0, bdiv_q} + (BW+1)'(1))); // R3

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (ws_o != $past(ws_o))) |-> ($past(bclk_o) && !bclk_o)); // R4

  AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (ws_o != $past(ws_o))) |-> ws_strobe_o); // R6

  AST_STROBE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ws_strobe_o |-> (ws_o != $past(ws_o))); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |=> (!mclk_o && !bclk_o && !ws_o && !ws_strobe_o && !cfg_err_o && !sync_err_o)); // R8
endmodule

bind audio_clk_gen acg_checker #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .run(run), .bdiv_q(bdiv_q),
  .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o), .ws_strobe_o(ws_strobe_o),
  .cfg_err_o(cfg_err_o), .sync_err_o(sync_err_o)
);

// File: tb/tb_audio_clk_gen.sv
module tb_audio_clk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [5:0] mclk_div = '0;
  logic [7:0] bclk_div = '0;
  logic [4:0] ws_code = '0;
  logic mclk_o, bclk_o, ws_o, ws_strobe_o, cfg_err_o, sync_err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  audio_clk_gen dut (
    .clk(clk), .rst(rst), .en(en), .mclk_div(mclk_div), .bclk_div(bclk_div),
    .ws_code(ws_code), .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o),
    .ws_strobe_o(ws_strobe_o), .cfg_err_o(cfg_err_o), .sync_err_o(sync_err_o)
  );

  // {M[6], B[8], W[5], cfg_err, sync_err}
  localparam logic [20:0] VEC [7] = '{
    {6'd1,  8'd0,  5'd0,  1'b0, 1'b0},
    {6'd2,  8'd1,  5'd16, 1'b0, 1'b1},
    {6'd4,  8'd2,  5'd20, 1'b1, 1'b1},
    {6'd3,  8'd3,  5'd5,  1'b0, 1'b0},
    {6'd5,  8'd0,  5'd31, 1'b1, 1'b1},
    {6'd63, 8'd15, 5'd0,  1'b0, 1'b0},
    {6'd1,  8'd0,  5'd17, 1'b1, 1'b0}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles, expected at most 150000", cyc);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return mclk_o;
      1: return bclk_o;
      default: return ws_o;
    endcase
  endfunction

  // measures one high and one low run; counts strobe mismatches on sel 2
  task automatic measure(input int sel, output int hi, output int lo, output int bad);
    logic prev;
    int guard;
    hi = 0; lo = 0; bad = 0; guard = 0;
    prev = pick(sel);
    while (pick(sel) != 1'b0 && guard < 20000) begin
      tick(); guard++;
      if (sel == 2 && ws_strobe_o != (ws_o != prev)) bad++;
      prev = ws_o;
    end
    while (pick(sel) != 1'b1 && guard < 20000) begin
      tick(); guard++;
      if (sel == 2 && ws_strobe_o != (ws_o != prev)) bad++;
      prev = ws_o;
    end
    while (pick(sel) == 1'b1 && guard < 20000) begin
      hi++; tick(); guard++;
      if (sel == 2 && ws_strobe_o != (ws_o != prev)) bad++;
      prev = ws_o;
    end
    while (pick(sel) == 1'b0 && guard < 20000) begin
      lo++; tick(); guard++;
      if (sel == 2 && ws_strobe_o != (ws_o != prev)) bad++;
      prev = ws_o;
    end
  endtask

  task automatic start(input logic [5:0] m, input logic [7:0] b, input logic [4:0] w);
    en = 1'b0;
    mclk_div = m; bclk_div = b; ws_code = w;
    repeat (3) tick();
    en = 1'b1;
    tick();
  endtask

  initial begin
    int hi, lo, bad;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R9 reset mclk", mclk_o, 0);
    check("R9 reset bclk/ws/strobe", {bclk_o, ws_o, ws_strobe_o}, 0);
    check("R9 reset flags", {cfg_err_o, sync_err_o}, 0);

    for (int i = 0; i < 7; i++) begin
      int m, b, w, wl, half, frame;
      m = int'(VEC[i][20:15]); b = int'(VEC[i][14:7]); w = int'(VEC[i][6:2]);
      wl = (w > 16) ? 32 : w + 16;
      half = (b + 1) * 2 * wl;
      frame = 2 * half;
      start(VEC[i][20:15], VEC[i][14:7], VEC[i][6:2]);
      repeat (frame + 8) tick();
      measure(0, hi, lo, bad);
      check("R1 mclk high", hi, (m + 2) / 2);
      check("R1 mclk low", lo, (m + 1) / 2);
      measure(1, hi, lo, bad);
      check("R3 bclk high", hi, b + 1);
      check("R3 bclk low", lo, b + 1);
      measure(2, hi, lo, bad);
      check("R4 ws high", hi, half);
      check("R4 ws low", lo, half);
      check("R6 strobe mismatches", bad, 0);
      check("R5 cfg_err", cfg_err_o, int'(VEC[i][1]));
      check("R7 sync_err", sync_err_o, ((frame % (m + 1)) != 0) ? 1 : 0);
      check("R7 sync_err table", sync_err_o, int'(VEC[i][0]));
    end

    // R2: divide-by-one follows the peripheral clock level
    start(6'd0, 8'd1, 5'd0);
    repeat (4) tick();
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      check("R2 bypass high phase", mclk_o, 1);
      @(negedge clk); #2;
      check("R2 bypass low phase", mclk_o, 0);
    end

    // R8: fields changed while running are ignored
    start(6'd3, 8'd3, 5'd5);
    repeat (20) tick();
    mclk_div = 6'd1; bclk_div = 8'd0; ws_code = 5'd20;
    repeat (400) tick();
    measure(1, hi, lo, bad);
    check("R8 bclk unchanged after field write", hi, 4);
    check("R8 cfg_err unchanged after field write", cfg_err_o, 0);
    en = 1'b0;
    tick(); tick();
    check("R8 outputs low after disable", {mclk_o, bclk_o, ws_o, ws_strobe_o, cfg_err_o, sync_err_o}, 0);
    repeat (30) tick();
    check("R8 outputs stay low", {mclk_o, bclk_o, ws_o, ws_strobe_o}, 0);
    en = 1'b1;
    repeat (10) tick();
    measure(1, hi, lo, bad);
    check("R8 new bclk after re-enable", hi, 1);
    check("R5 cfg_err after re-enable with code 20", cfg_err_o, 1);

    finish_run();
  end
endmodule